// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Flash and Sensor Control Pins

This block is a small bank of 32-bit registers behind a simple single-cycle request bus. It holds two general-purpose ports, A and D, each with an output-value register, an input-view register and a direction (output-enable) register. The remaining words of the window are plain scratch storage that reads back what was written.

Three bits of the port A output value drive the control lines of an external NAND flash: address latch, command latch and chip enable. Port D carries a bit-banged serial temperature sensor. A write to the port D output value that flips the sensor-clock bit produces a one-cycle event pulse, together with the new clock level and the data bit, which the external sensor model consumes. Reading either input-view register returns the driven value masked by its direction register, with a live status pin from the attached device merged in.

Top module: `gpio_periph_port`

## Requirements
- R1: After synchronous reset every register reads zero, the three flash control outputs are low and the sensor event, level and data outputs are low.
- R2: A word index other than the two input views (index = byte address >> 2) returns on read the last full value written to it; indices 5 and 22 are used as examples.
- R3: A read of word index 1 returns (word 0 AND word 2) with bit 7 forced to one when `nand_rdy` is high.
- R4: A read of word index 0x11 returns (word 0x10 AND word 0x12) with bit 4 forced to one when `sensor_dout` is high.
- R5: A write to word index 0 stores the whole value; in the cycle after it `nand_ale` equals bit 6, `nand_cle` bit 5 and `nand_ce` bit 4 of the written value.
- R6: A write to word index 0x10 whose bit 1 differs from the stored bit 1 raises `sensor_clk_evt` for exactly one cycle, in the cycle after the write, with `sensor_clk_lvl` equal to the new bit 1 and `sensor_clk_dat` equal to bit 4; the value is stored.
- R7: A write to word index 0x10 that keeps bit 1 unchanged raises no event, and `sensor_clk_lvl` and `sensor_clk_dat` keep their previous values.
- R8: An access at byte address 0x5C or above is ignored when writing and returns zero when reading.
- R9: An access with `req_be` not equal to 4'b1111, or with address bits [1:0] not zero, is ignored when writing and returns zero when reading.
- R10: `rsp_valid` is high in the cycle after each read request and only then; `rsp_rdata` is zero when there is no response.
- R11: Writes to the two input-view indices (1 and 0x11) do not change what those indices read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the block |
| req_be | input | 4 | Byte enables; only 4'b1111 is a valid access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| nand_ale | output | 1 | Flash address latch enable |
| nand_cle | output | 1 | Flash command latch enable |
| nand_ce | output | 1 | Flash chip enable |
| nand_rdy | input | 1 | Flash ready status |
| sensor_clk_evt | output | 1 | One-cycle sensor clock edge event |
| sensor_clk_lvl | output | 1 | New sensor clock level |
| sensor_clk_dat | output | 1 | Data bit presented to the sensor |
| sensor_dout | input | 1 | Serial output from the sensor |

## Verification
The bench targets the sensor clock detector, writing values that flip the clock bit, keep it, and flip it back, since a detector comparing against the new value rather than the stored one would never fire, and one comparing the whole word would fire on data-only changes. It reads the input views with the status pins both low and high and after stray writes to them, which catches a read path that returns raw storage or drops the merged bit. Partial byte enables, unaligned and out-of-window addresses are used against a word holding a known value, so a qualifier that lets them through corrupts that word or returns non-zero data.

// File: rtl/gpio_pp_pkg.sv
package gpio_pp_pkg;

    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int WIN_BYTES = 'h5C;
    localparam int NUM_WORDS = WIN_BYTES / BE_W;
    localparam int IDX_W     = $clog2(NUM_WORDS);

    typedef logic [IDX_W-1:0]  widx_t;
    typedef logic [DATA_W-1:0] word_t;

    // Word indices whose position the decoders depend on
    localparam widx_t IDX_A_OUT = widx_t'(0);
    localparam widx_t IDX_A_IN  = widx_t'(1);
    localparam widx_t IDX_A_OE  = widx_t'(2);
    localparam widx_t IDX_D_OUT = widx_t'(16);
    localparam widx_t IDX_D_IN  = widx_t'(17);
    localparam widx_t IDX_D_OE  = widx_t'(18);

    // Bit positions shared with the attached devices
    localparam int BIT_ALE      = 6;
    localparam int BIT_CLE      = 5;
    localparam int BIT_CE       = 4;
    localparam int BIT_RDY      = 7;
    localparam int BIT_SENS_CLK = 1;
    localparam int BIT_SENS_DAT = 4;
    localparam int BIT_SENS_OUT = 4;

    typedef struct packed {
        logic  rd;     // read request, qualified or not
        logic  wr;     // qualified write
        logic  ok;     // access is full-width, aligned and in window
        widx_t idx;
        word_t wdata;
    } acc_t;

    function automatic logic is_input_view(widx_t i);
        return (i == IDX_A_IN) || (i == IDX_D_IN);
    endfunction

endpackage

// File: rtl/gpio_pp_decode.sv
module gpio_pp_decode
    import gpio_pp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  word_t             wdata,
    output acc_t              acc
);

    localparam int LSB_W = $clog2(BE_W);

    logic in_window;
    logic aligned;
    logic full_be;

    always_comb begin
        in_window = (int'(addr) < WIN_BYTES);
        aligned   = (addr[LSB_W-1:0] == '0);
        full_be   = (be == '1);

        acc.ok    = in_window && aligned && full_be;
        acc.rd    = valid && !write;
        acc.wr    = valid && write && acc.ok;
        acc.idx   = addr[LSB_W +: IDX_W];
        acc.wdata = wdata;
    end

endmodule

// File: rtl/gpio_pp_regfile.sv
module gpio_pp_regfile
    import gpio_pp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  acc_t  acc,
    output word_t rd_word,
    output word_t a_out,
    output word_t a_oe,
    output word_t d_out,
    output word_t d_oe
);

    word_t regs [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        if (is_input_view(widx_t'(i))) begin : g_view
            // Input views have no storage; their read value is built outside
            assign regs[i] = '0;
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[i] <= '0;
                end else if (acc.wr && (acc.idx == widx_t'(i))) begin
                    regs[i] <= acc.wdata;
                end
            end
        end
    end

    always_comb begin
        if (int'(acc.idx) < NUM_WORDS) begin
            rd_word = regs[acc.idx];
        end else begin
            rd_word = '0;
        end
    end

    assign a_out = regs[IDX_A_OUT];
    assign a_oe  = regs[IDX_A_OE];
    assign d_out = regs[IDX_D_OUT];
    assign d_oe  = regs[IDX_D_OE];

endmodule

// File: rtl/gpio_pp_sensor_clk.sv
module gpio_pp_sensor_clk
    import gpio_pp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t acc,
    input  logic clk_bit_q,   // stored clock bit before this write
    output logic evt,
    output logic lvl,
    output logic dat
);

    logic hit;
    logic new_lvl;
    logic new_dat;

    always_comb begin
        new_lvl = acc.wdata[BIT_SENS_CLK];
        new_dat = acc.wdata[BIT_SENS_DAT];
        hit     = acc.wr && (acc.idx == IDX_D_OUT) && (new_lvl != clk_bit_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= 1'b0;
            lvl <= 1'b0;
            dat <= 1'b0;
        end else begin
            evt <= hit;
            if (hit) begin
                lvl <= new_lvl;
                dat <= new_dat;
            end
        end
    end

endmodule

// File: rtl/gpio_periph_port.sv
module gpio_periph_port
    import gpio_pp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              nand_ale,
    output logic              nand_cle,
    output logic              nand_ce,
    input  logic              nand_rdy,
    output logic              sensor_clk_evt,
    output logic              sensor_clk_lvl,
    output logic              sensor_clk_dat,
    input  logic              sensor_dout
);

    acc_t  acc;
    word_t rd_word;
    word_t a_out, a_oe, d_out, d_oe;
    word_t rd_val;

    gpio_pp_decode #(.ADDR_W(ADDR_W)) u_decode (
        .valid (req_valid),
        .write (req_write),
        .addr  (req_addr),
        .be    (req_be),
        .wdata (req_wdata),
        .acc   (acc)
    );

    gpio_pp_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .rd_word (rd_word),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .d_out   (d_out),
        .d_oe    (d_oe)
    );

    gpio_pp_sensor_clk u_sens (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .clk_bit_q (d_out[BIT_SENS_CLK]),
        .evt       (sensor_clk_evt),
        .lvl       (sensor_clk_lvl),
        .dat       (sensor_clk_dat)
    );

    // Input views merge driven outputs with live device status
    always_comb begin
        unique case (acc.idx)
            IDX_A_IN: begin
                rd_val = a_out & a_oe;
                rd_val[BIT_RDY] = rd_val[BIT_RDY] | nand_rdy;
            end
            IDX_D_IN: begin
                rd_val = d_out & d_oe;
                rd_val[BIT_SENS_OUT] = rd_val[BIT_SENS_OUT] | sensor_dout;
            end
            default: rd_val = rd_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc.rd;
            rsp_rdata <= (acc.rd && acc.ok) ? rd_val : '0;
        end
    end

    assign nand_ale = a_out[BIT_ALE];
    assign nand_cle = a_out[BIT_CLE];
    assign nand_ce  = a_out[BIT_CE];

endmodule

// File: rtl/gpio_periph_port_chk.sv
module gpio_periph_port_chk
    import gpio_pp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_be,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              nand_ale,
    input logic              sensor_clk_evt,
    input logic              sensor_clk_lvl,
    input logic              sensor_clk_dat
);

    localparam logic [ADDR_W-1:0] D_OUT_ADDR = ADDR_W'(int'(IDX_D_OUT) * 4);

    logic rd_req, full_wr;
    assign rd_req  = req_valid && !req_write;
    assign full_wr = req_valid && req_write && (req_be == 4'hF);

    p_rsp_only_after_read_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(rd_req));

    p_oob_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (int'(req_addr) >= WIN_BYTES)) |=> (rsp_rdata == '0));

    p_partial_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (req_be != 4'hF)) |=> (rsp_rdata == '0));

    p_evt_needs_write_r6: assert property (@(posedge clk) disable iff (rst)
        sensor_clk_evt |-> $past(full_wr && (req_addr == D_OUT_ADDR)));

    p_level_held_r7: assert property (@(posedge clk) disable iff (rst)
        !sensor_clk_evt |-> ($stable(sensor_clk_lvl) && $stable(sensor_clk_dat)));

    p_ale_follows_write_r5: assert property (@(posedge clk) disable iff (rst)
        (full_wr && (req_addr == '0)) |=> (nand_ale == $past(req_wdata[BIT_ALE])));

endmodule

bind gpio_periph_port gpio_periph_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_be         (req_be),
    .req_wdata      (req_wdata),
    .rsp_valid      (rsp_valid),
    .rsp_rdata      (rsp_rdata),
    .nand_ale       (nand_ale),
    .sensor_clk_evt (sensor_clk_evt),
    .sensor_clk_lvl (sensor_clk_lvl),
    .sensor_clk_dat (sensor_clk_dat)
);

// File: tb/gpio_periph_port_tb.sv
`timescale 1ns/1ps
module gpio_periph_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        nand_ale, nand_cle, nand_ce;
    logic        nand_rdy = 1'b0;
    logic        sensor_clk_evt, sensor_clk_lvl, sensor_clk_dat;
    logic        sensor_dout = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_periph_port #(.ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .nand_ale(nand_ale), .nand_cle(nand_cle), .nand_ce(nand_ce),
        .nand_rdy(nand_rdy),
        .sensor_clk_evt(sensor_clk_evt), .sensor_clk_lvl(sensor_clk_lvl),
        .sensor_clk_dat(sensor_clk_dat), .sensor_dout(sensor_dout)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic        chk;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h14, 4'hF, 32'hA5A5_0F0F, 1'b0, 32'h0},          // R2 store idx 5
        '{1'b0, 8'h14, 4'hF, 32'h0,         1'b1, 32'hA5A5_0F0F},  // R2
        '{1'b1, 8'h58, 4'hF, 32'h1234_5678, 1'b0, 32'h0},          // R2 store idx 22
        '{1'b0, 8'h58, 4'hF, 32'h0,         1'b1, 32'h1234_5678},  // R2
        '{1'b1, 8'h5C, 4'hF, 32'hDEAD_BEEF, 1'b0, 32'h0},          // R8 out of window
        '{1'b0, 8'h5C, 4'hF, 32'h0,         1'b1, 32'h0},          // R8
        '{1'b1, 8'h14, 4'h3, 32'h0,         1'b0, 32'h0},          // R9 partial write
        '{1'b0, 8'h14, 4'hF, 32'h0,         1'b1, 32'hA5A5_0F0F},  // R9 unchanged
        '{1'b0, 8'h14, 4'h7, 32'h0,         1'b1, 32'h0},          // R9 partial read
        '{1'b1, 8'h16, 4'hF, 32'h0,         1'b0, 32'h0},          // R9 unaligned write
        '{1'b0, 8'h14, 4'hF, 32'h0,         1'b1, 32'hA5A5_0F0F},  // R9 unchanged
        '{1'b1, 8'h00, 4'hF, 32'h0000_00F3, 1'b0, 32'h0},          // R5 A out
        '{1'b1, 8'h08, 4'hF, 32'h0F0F_0041, 1'b0, 32'h0},          // R3 A oe
        '{1'b0, 8'h04, 4'hF, 32'h0,         1'b1, 32'h0000_0041},  // R3 masked view
        '{1'b0, 8'h00, 4'hF, 32'h0,         1'b1, 32'h0000_00F3},  // R5 full value stored
        '{1'b1, 8'h04, 4'hF, 32'hFFFF_FFFF, 1'b0, 32'h0},          // R11 write to view
        '{1'b0, 8'h04, 4'hF, 32'h0,         1'b1, 32'h0000_0041},  // R11
        '{1'b1, 8'h48, 4'hF, 32'h0000_FF00, 1'b0, 32'h0}           // R4 D oe
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request for one cycle; outputs are sampled at the following negedge
    task automatic access(input logic wr, input logic [7:0] addr, input logic [3:0] be,
                          input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();

        // R1: reset state
        check("R1 ale/cle/ce", {29'd0, nand_ale, nand_cle, nand_ce}, 32'd0);
        check("R1 sensor outs", {29'd0, sensor_clk_evt, sensor_clk_lvl, sensor_clk_dat}, 32'd0);
        access(1'b0, 8'h00, 4'hF, 32'h0);
        check("R1 A out", rsp_rdata, 32'h0);
        access(1'b0, 8'h48, 4'hF, 32'h0);
        check("R1 D oe", rsp_rdata, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].wdata);
            if (VECS[i].chk) check($sformatf("vec %0d", i), rsp_rdata, VECS[i].exp);
        end

        // R5: flash control lines follow A out bits 6,5,4 one cycle after the write
        access(1'b1, 8'h00, 4'hF, 32'h0000_0050);
        check("R5 pins after 0x50", {29'd0, nand_ale, nand_cle, nand_ce}, 32'b101);
        access(1'b1, 8'h00, 4'hF, 32'h0000_0020);
        check("R5 pins after 0x20", {29'd0, nand_ale, nand_cle, nand_ce}, 32'b010);
        access(1'b1, 8'h00, 4'hF, 32'h0000_00C1);   // restore A out so view reads 0x41

        // R3: ready pin merged into bit 7
        nand_rdy = 1'b1;
        access(1'b0, 8'h04, 4'hF, 32'h0);
        check("R3 rdy merged", rsp_rdata, 32'h0000_00C1);
        nand_rdy = 1'b0;

        // R10: response strobe only after reads
        access(1'b1, 8'h14, 4'hF, 32'h0000_0001);
        check("R10 no rsp after write", {31'd0, rsp_valid}, 32'd0);
        check("R10 rdata zero w/o rsp", rsp_rdata, 32'd0);
        access(1'b0, 8'h14, 4'hF, 32'h0);
        check("R10 rsp after read", {31'd0, rsp_valid}, 32'd1);
        idle();
        check("R10 rsp one cycle", {31'd0, rsp_valid}, 32'd0);

        // R7: D out write keeping clock bit low: no event
        access(1'b1, 8'h40, 4'hF, 32'h0000_1200);
        check("R7 no evt", {31'd0, sensor_clk_evt}, 32'd0);
        access(1'b1, 8'h40, 4'hF, 32'h0000_1210);
        check("R7 no evt data-only", {31'd0, sensor_clk_evt}, 32'd0);
        check("R7 lvl/dat held", {30'd0, sensor_clk_lvl, sensor_clk_dat}, 32'd0);

        // R4: masked D view plus sensor output bit
        access(1'b0, 8'h44, 4'hF, 32'h0);
        check("R4 D view", rsp_rdata, 32'h0000_1200);
        sensor_dout = 1'b1;
        access(1'b0, 8'h44, 4'hF, 32'h0);
        check("R4 sensor bit merged", rsp_rdata, 32'h0000_1210);
        sensor_dout = 1'b0;

        // R6: rising clock bit with data bit 1
        access(1'b1, 8'h40, 4'hF, 32'h0000_1212);
        check("R6 evt rise", {29'd0, sensor_clk_evt, sensor_clk_lvl, sensor_clk_dat}, 32'b111);
        idle();
        check("R6 evt single cycle", {31'd0, sensor_clk_evt}, 32'd0);
        // R7: level stays high, no new event
        access(1'b1, 8'h40, 4'hF, 32'h0000_0002);
        check("R7 high kept", {29'd0, sensor_clk_evt, sensor_clk_lvl, sensor_clk_dat}, 32'b011);
        // R6: falling clock bit with data 0
        access(1'b1, 8'h40, 4'hF, 32'h0000_0000);
        check("R6 evt fall", {29'd0, sensor_clk_evt, sensor_clk_lvl, sensor_clk_dat}, 32'b100);
        // R6 with R9: partial write of the clock bit gives no event
        access(1'b1, 8'h40, 4'h1, 32'h0000_0002);
        check("R6 partial no evt", {31'd0, sensor_clk_evt}, 32'd0);
        // R11: write to D view leaves it unchanged
        access(1'b1, 8'h44, 4'hF, 32'hFFFF_FFFF);
        access(1'b0, 8'h44, 4'hF, 32'h0);
        check("R11 D view", rsp_rdata, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule